// File: doc/BRIEF.md
# Dual-Clock FIFO Level Flags

This block produces two level indications for a FIFO whose writer and reader run on unrelated clocks: a half-full flag and a programmable low-water flag, both active low. It keeps its own write and read counters, advanced by the write-enable and read-enable strobes on their own clocks. Each counter crosses to the other clock as Gray code through a two-stage synchronizer. The storage array, the data path, the full and empty flags and the loading of the offset value are outside the block. The connecting logic must never write when the FIFO is full or read when it is empty.

The low-water flag is asserted while the stored word count is at or below the programmed level. It runs in one of two timings. In the split timing, a read-clock edge asserts it and a write-clock edge releases it, so each edge appears as early as possible. In the read-only timing, it is a register on the read clock and changes nowhere else. The half-full flag is always split between the clocks: a write-clock edge sets it and a read-clock edge clears it. It is therefore an asynchronous output. In show-ahead mode the output register holds one extra word, so the half-full threshold rises by one.

The mode, timing select and level inputs are static and change only while reset is held. Each split flag is a pair of toggle bits, one per domain. The flag is active while the two bits disagree (half-full) or agree (low-water). Each domain may flip its own bit only when its synchronized view of the other bit shows the flag in the opposite state.

Top module: `fifo_level_flags`

## Requirements
- R1: While reset is held, low_water_n is 0 (asserted) and half_flag_n is 1, and both counters are zero.
- R2: With show_ahead = 0, starting from reset with no reads, half_flag_n stays 1 through the first D/2 writes and falls on the write-clock edge of write number D/2 + 1, where D = 2**ADDR_W.
- R3: With show_ahead = 1, starting from reset with no reads, half_flag_n stays 1 through the first D/2 + 1 writes and falls on the write-clock edge of write number D/2 + 2.
- R4: When the read side already sees the flag as set, half_flag_n rises on the read-clock edge of the read that brings the word count to the threshold or below. The threshold is D/2, or D/2 + 1 in show-ahead mode.
- R5: With lw_rd_only = 0, low_water_n rises on the write-clock edge of the write that takes the word count above lw_level.
- R6: With lw_rd_only = 0, low_water_n falls on the read-clock edge of the read that brings the word count to lw_level or below.
- R7: With lw_rd_only = 1, low_water_n changes only on read-clock edges. A write that lifts the count above lw_level leaves it unchanged at that write edge, and it rises within four read-clock edges. A read that brings the count to lw_level or below makes it fall on that read edge.
- R8: After any mix of writes, reads and simultaneous writes and reads, once both clocks have run idle for eight cycles each, half_flag_n = 0 exactly when count > threshold and low_water_n = 0 exactly when count <= lw_level, in both timings and both modes. The write counter's Gray code changes by at most one bit per write clock.
- R9: lw_level is ADDR_W+1 bits wide and accepts 0 to D. With 0, a single stored word releases the flag. With D, the flag stays asserted even when the FIFO is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_en | input | 1 | Write strobe, one word per write-clock edge |
| rd_clk | input | 1 | Read clock |
| rd_en | input | 1 | Read strobe, one word per read-clock edge |
| rst_n | input | 1 | Asynchronous reset for both domains, active low |
| lw_level | input | ADDR_W+1 | Low-water level in words, 0 to D |
| show_ahead | input | 1 | 1 selects show-ahead mode (threshold D/2 + 1) |
| lw_rd_only | input | 1 | 1 selects read-clock-only low-water timing |
| low_water_n | output | 1 | Low-water flag, active low |
| half_flag_n | output | 1 | Half-full flag, active low |

## Verification
A write and a read can land close together in the same window, so each domain updates its half of a flag from a stale view of the other counter. This can also happen while a toggle handshake is still in flight. The bench provokes this by launching write and read strobes concurrently with random counts, near both thresholds and with random levels. It then lets both clocks idle and compares each flag with the word count from its own model. Directed sequences judge the exact edge of each transition, sampling two nanoseconds after the clock edge that should cause it and before the next one.

// File: rtl/ffg_pkg.sv
package ffg_pkg;

    // synchronizer depth shared by every crossing of the block
    localparam int SYNC_STAGES = 2;

    // one toggle bit per split flag, owned by one clock domain
    typedef struct packed {
        logic half;
        logic lowm;
    } tgl_pair_t;

endpackage

// File: rtl/ffg_sync.sv
module ffg_sync #(
    parameter int W      = 1,
    parameter int STAGES = ffg_pkg::SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef logic [STAGES-1:0][W-1:0] chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d    = chain_q;
        chain_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/ffg_wr_side.sv
module ffg_wr_side
    import ffg_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              show_ahead,
    input  logic              lw_rd_only,
    input  logic [ADDR_W:0]   lw_level,
    input  logic [ADDR_W:0]   rgray_s,
    input  tgl_pair_t         rd_tgl_s,
    output logic [ADDR_W:0]   wgray,
    output tgl_pair_t         wr_tgl
);

    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [PW-1:0] HALF = PW'(DEPTH / 2);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        tgl_pair_t     tgl;
    } wst_t;

    wst_t          st_d, st_q;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] occ;
    logic [PW-1:0] thr;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.bin  = st_q.bin + PW'(wr_en);
        st_d.gray = to_gray(st_d.bin);
        rbin_s    = from_gray(rgray_s);
        // the stale read view can only overstate the count
        occ       = st_d.bin - rbin_s;
        thr       = HALF + PW'(show_ahead);
        // set half-full only while this side sees it clear
        if (st_q.tgl.half == rd_tgl_s.half && occ > thr) begin
            st_d.tgl.half = ~st_q.tgl.half;
        end
        // release low-water only while this side sees it asserted
        if (!lw_rd_only && st_q.tgl.lowm == rd_tgl_s.lowm && occ > lw_level) begin
            st_d.tgl.lowm = ~st_q.tgl.lowm;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wgray  = st_q.gray;
    assign wr_tgl = st_q.tgl;

endmodule

// File: rtl/ffg_rd_side.sv
module ffg_rd_side
    import ffg_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              show_ahead,
    input  logic              lw_rd_only,
    input  logic [ADDR_W:0]   lw_level,
    input  logic [ADDR_W:0]   wgray_s,
    input  tgl_pair_t         wr_tgl_s,
    output logic [ADDR_W:0]   rgray,
    output tgl_pair_t         rd_tgl,
    output logic              lw_level_hit
);

    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [PW-1:0] HALF = PW'(DEPTH / 2);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        tgl_pair_t     tgl;
        logic          hit;
    } rst_t;

    rst_t          st_d, st_q;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] occ;
    logic [PW-1:0] thr;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.bin  = st_q.bin + PW'(rd_en);
        st_d.gray = to_gray(st_d.bin);
        wbin_s    = from_gray(wgray_s);
        // the stale write view can only understate the count
        occ       = wbin_s - st_d.bin;
        thr       = HALF + PW'(show_ahead);
        // clear half-full only while this side sees it set
        if (st_q.tgl.half != wr_tgl_s.half && occ <= thr) begin
            st_d.tgl.half = ~st_q.tgl.half;
        end
        // assert low-water only while this side sees it released
        if (!lw_rd_only && st_q.tgl.lowm != wr_tgl_s.lowm && occ <= lw_level) begin
            st_d.tgl.lowm = ~st_q.tgl.lowm;
        end
        // read-clock-only timing: plain registered compare
        st_d.hit = (occ <= lw_level);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.hit <= 1'b1;
        end else begin
            st_q     <= st_d;
        end
    end

    assign rgray        = st_q.gray;
    assign rd_tgl       = st_q.tgl;
    assign lw_level_hit = st_q.hit;

endmodule

// File: rtl/fifo_level_flags.sv
module fifo_level_flags
    import ffg_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic            wr_clk,
    input  logic            wr_en,
    input  logic            rd_clk,
    input  logic            rd_en,
    input  logic            rst_n,
    input  logic [ADDR_W:0] lw_level,
    input  logic            show_ahead,
    input  logic            lw_rd_only,
    output logic            low_water_n,
    output logic            half_flag_n
);

    localparam int PW = ADDR_W + 1;
    localparam int XW = PW + 2;

    logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
    tgl_pair_t     wr_tgl, rd_tgl, wr_tgl_s, rd_tgl_s;
    logic [XW-1:0] wside_s, rside_s;
    logic          lw_level_hit;

    ffg_wr_side #(.ADDR_W(ADDR_W)) u_wr (
        .clk        (wr_clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .show_ahead (show_ahead),
        .lw_rd_only (lw_rd_only),
        .lw_level   (lw_level),
        .rgray_s    (rgray_s),
        .rd_tgl_s   (rd_tgl_s),
        .wgray      (wgray),
        .wr_tgl     (wr_tgl)
    );

    ffg_rd_side #(.ADDR_W(ADDR_W)) u_rd (
        .clk          (rd_clk),
        .rst_n        (rst_n),
        .rd_en        (rd_en),
        .show_ahead   (show_ahead),
        .lw_rd_only   (lw_rd_only),
        .lw_level     (lw_level),
        .wgray_s      (wgray_s),
        .wr_tgl_s     (wr_tgl_s),
        .rgray        (rgray),
        .rd_tgl       (rd_tgl),
        .lw_level_hit (lw_level_hit)
    );

    // pointer and toggles travel in one synchronizer so they stay aligned
    ffg_sync #(.W(XW)) u_w2r (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .din   ({wgray, wr_tgl}),
        .dout  (wside_s)
    );

    ffg_sync #(.W(XW)) u_r2w (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .din   ({rgray, rd_tgl}),
        .dout  (rside_s)
    );

    assign wgray_s  = wside_s[XW-1:2];
    assign wr_tgl_s = wside_s[1:0];
    assign rgray_s  = rside_s[XW-1:2];
    assign rd_tgl_s = rside_s[1:0];

    // half-full is active while the toggles disagree
    assign half_flag_n = ~(wr_tgl.half ^ rd_tgl.half);
    // low-water is active while the toggles agree
    assign low_water_n = lw_rd_only ? ~lw_level_hit : (wr_tgl.lowm ^ rd_tgl.lowm);

endmodule

// File: rtl/ffg_checker.sv
module ffg_checker #(
    parameter int ADDR_W = 4
) (
    input logic            wr_clk,
    input logic            rd_clk,
    input logic            rst_n,
    input logic            lw_rd_only,
    input logic            low_water_n,
    input logic            half_flag_n,
    input logic [ADDR_W:0] wgray
);

    // R1
    always @(posedge rd_clk) begin
        if (rst_n === 1'b0) begin
            reset_state_chk: assert (low_water_n === 1'b0 && half_flag_n === 1'b1);
        end
    end

    // R2
    always @(negedge half_flag_n) begin
        if (rst_n === 1'b1) begin
            half_set_edge_chk: assert (wr_clk === 1'b1);
        end
    end

    // R4
    always @(posedge half_flag_n) begin
        if (rst_n === 1'b1) begin
            half_clr_edge_chk: assert (rd_clk === 1'b1);
        end
    end

    // R5
    always @(posedge low_water_n) begin
        if (rst_n === 1'b1 && lw_rd_only === 1'b0) begin
            lw_release_edge_chk: assert (wr_clk === 1'b1);
        end
    end

    // R6
    always @(negedge low_water_n) begin
        if (rst_n === 1'b1 && lw_rd_only === 1'b0) begin
            lw_assert_edge_chk: assert (rd_clk === 1'b1);
        end
    end

    // R7
    always @(low_water_n) begin
        if (rst_n === 1'b1 && lw_rd_only === 1'b1) begin
            lw_rd_only_edge_chk: assert (rd_clk === 1'b1);
        end
    end

    // R8
    gray_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

endmodule

bind fifo_level_flags ffg_checker #(.ADDR_W(ADDR_W)) u_ffg_checker (
    .wr_clk      (wr_clk),
    .rd_clk      (rd_clk),
    .rst_n       (rst_n),
    .lw_rd_only  (lw_rd_only),
    .low_water_n (low_water_n),
    .half_flag_n (half_flag_n),
    .wgray       (wgray)
);

// File: tb/fifo_level_flags_bench.sv
`timescale 1ns/100ps
module fifo_level_flags_bench;

    localparam int  ADDR_W     = 4;
    localparam int  D          = 1 << ADDR_W;
    localparam real CLK_PERIOD = 10.0;
    localparam real RD_HALF    = 7.0;

    logic            wr_clk = 1'b0;
    logic            rd_clk = 1'b0;
    logic            rst_n  = 1'b0;
    logic            wr_en  = 1'b0;
    logic            rd_en  = 1'b0;
    logic [ADDR_W:0] lw_level = '0;
    logic            show_ahead = 1'b0;
    logic            lw_rd_only = 1'b0;
    logic            low_water_n;
    logic            half_flag_n;

    int total = 0;
    int bad   = 0;
    int occ   = 0;
    bit done  = 1'b0;

    fifo_level_flags #(.ADDR_W(ADDR_W)) u_fifo_level_flags (
        .wr_clk      (wr_clk),
        .wr_en       (wr_en),
        .rd_clk      (rd_clk),
        .rd_en       (rd_en),
        .rst_n       (rst_n),
        .lw_level    (lw_level),
        .show_ahead  (show_ahead),
        .lw_rd_only  (lw_rd_only),
        .low_water_n (low_water_n),
        .half_flag_n (half_flag_n)
    );

    always #(CLK_PERIOD / 2.0) wr_clk = ~wr_clk;
    initial begin
        #0.5;
        forever #(RD_HALF) rd_clk = ~rd_clk;
    end

    function automatic int half_thr();
        return D / 2 + int'(show_ahead);
    endfunction

    function automatic logic exp_half_n(int words);
        return (words > half_thr()) ? 1'b0 : 1'b1;
    endfunction

    function automatic logic exp_lw_n(int words);
        return (words <= int'(lw_level)) ? 1'b0 : 1'b1;
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (words=%0d)", req, act, exp, occ);
        end
    endtask

    task automatic do_reset(bit sa, bit rdonly, int lvl);
        rst_n      = 1'b0;
        wr_en      = 1'b0;
        rd_en      = 1'b0;
        show_ahead = sa;
        lw_rd_only = rdonly;
        lw_level   = (ADDR_W+1)'(lvl);
        occ        = 0;
        #(CLK_PERIOD * 3);
        chk("R1 low_water_n in reset", int'(low_water_n), 0);
        chk("R1 half_flag_n in reset", int'(half_flag_n), 1);
        @(posedge wr_clk);
        #2;
        rst_n = 1'b1;
    endtask

    // returns 2 ns after the write edge
    task automatic wr_pulse();
        @(posedge wr_clk);
        #2;
        wr_en = 1'b1;
        @(posedge wr_clk);
        #2;
        wr_en = 1'b0;
    endtask

    // returns 2 ns after the read edge
    task automatic rd_pulse();
        @(posedge rd_clk);
        #2;
        rd_en = 1'b1;
        @(posedge rd_clk);
        #2;
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(posedge rd_clk);
        repeat (8) @(posedge wr_clk);
        #2;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd2718));

        // standard mode, split low-water timing, level 3
        do_reset(1'b0, 1'b0, 3);
        for (int i = 1; i <= D / 2 + 1; i++) begin
            wr_pulse();
            occ++;
            chk("R2 half_flag_n after write", int'(half_flag_n), (i >= D / 2 + 1) ? 0 : 1);
            chk("R5 low_water_n after write", int'(low_water_n), (i >= 4) ? 1 : 0);
        end
        settle();
        chk("R4 half_flag_n held before read", int'(half_flag_n), 0);
        rd_pulse();
        occ--;
        chk("R4 half_flag_n at threshold read", int'(half_flag_n), 1);
        while (occ > 0) begin
            rd_pulse();
            occ--;
            chk("R6 low_water_n after read", int'(low_water_n), (occ <= 3) ? 0 : 1);
            chk("R4 half_flag_n stays clear", int'(half_flag_n), 1);
        end

        // show-ahead mode, level D
        do_reset(1'b1, 1'b0, D);
        for (int i = 1; i <= D / 2 + 2; i++) begin
            wr_pulse();
            occ++;
            chk("R3 half_flag_n after write", int'(half_flag_n), (i >= D / 2 + 2) ? 0 : 1);
            chk("R9 low_water_n at level D", int'(low_water_n), 0);
        end
        while (occ < D) begin
            wr_pulse();
            occ++;
        end
        settle();
        chk("R9 low_water_n with FIFO full, level D", int'(low_water_n), 0);
        chk("R3 half_flag_n with FIFO full", int'(half_flag_n), 0);

        // level 0
        do_reset(1'b0, 1'b0, 0);
        wr_pulse();
        occ++;
        chk("R9 low_water_n one word, level 0", int'(low_water_n), 1);
        settle();
        rd_pulse();
        occ--;
        chk("R9 low_water_n empty, level 0", int'(low_water_n), 0);

        // read-clock-only low-water timing, level 2
        do_reset(1'b0, 1'b1, 2);
        for (int i = 1; i <= 3; i++) begin
            wr_pulse();
            occ++;
            chk("R7 low_water_n unchanged at write edge", int'(low_water_n), 0);
        end
        begin
            int edges = 0;
            while (low_water_n == 1'b0 && edges < 8) begin
                @(posedge rd_clk);
                #2;
                edges++;
            end
            chk("R7 read edges until release within 4", (edges <= 4) ? 1 : 0, 1);
            chk("R7 low_water_n released", int'(low_water_n), 1);
        end
        settle();
        rd_pulse();
        occ--;
        chk("R7 low_water_n at read edge", int'(low_water_n), 0);

        // random mixed traffic
        for (int round = 0; round < 4; round++) begin
            do_reset(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     int'($urandom_range(0, D)));
            for (int burst = 0; burst < 40; burst++) begin
                int ops = int'($urandom_range(1, 6));
                for (int k = 0; k < ops; k++) begin
                    int pick = int'($urandom_range(0, 2));
                    if (pick == 2 && occ > 0 && occ < D) begin
                        fork
                            wr_pulse();
                            rd_pulse();
                        join
                    end else if (pick == 0 && occ < D) begin
                        wr_pulse();
                        occ++;
                    end else if (pick == 1 && occ > 0) begin
                        rd_pulse();
                        occ--;
                    end
                end
                settle();
                chk("R8 half_flag_n settled", int'(half_flag_n), int'(exp_half_n(occ)));
                chk("R8 low_water_n settled", int'(low_water_n), int'(exp_lw_n(occ)));
            end
        end

        done = 1'b1;
        finish_run();
    end

endmodule